// File: doc/BRIEF.md
# Lane-Pair Ownership and Issue-Width Controller

This block decides how the execution lanes of a wide VLIW core are shared among hardware thread contexts. Lanes are grouped in pairs. A mapping word holds one small field per lane pair. Each field either names the context that owns the pair or marks the pair as idle. From the committed mapping the block works out three things: the issue width of each context, which contexts may run, and which context each shared memory port serves. When several pairs belong to one context, those pairs act as one merged core. When the pairs belong to different contexts, each context runs its own program on a narrower slice.

Supervisor software writes a new mapping through a single write strobe. The block first checks the mapping. An illegal mapping is refused with an error flag, and the mapping in force stays as it was. A legal mapping is held as pending. The block then raises a flush request and holds every context. It waits for the pipeline to report that the flush has finished, installs the pending mapping and raises a done flag. A context that owns no pair is suspended. Its program state lives elsewhere and is untouched, so it can run again once a later mapping gives it lanes.

Top module: `lanepair_ctx_mapper`

## Requirements
- R1: After reset, every lane pair belongs to context 0. With the default 4 pairs, activeMap is 8'h55, context 0 has issue width 8, context 1 has width 0, ctxRun is 2'b01, and flushReq, cfgDone and cfgErr are all 0.
- R2: Bits [2k+1:2k] of a mapping describe lane pair k. Code 0 means the pair is idle. Code c+1 gives the pair to context c. Codes above the number of contexts (code 3 by default) are out of range.
- R3: A legal write accepted while no flush is pending raises flushReq on the next cycle and clears cfgDone. From then until the commit, ctxRun is all zero and activeMap keeps its old value.
- R4: A clock edge that samples flushDone high while flushReq is high installs the pending mapping into activeMap, drops flushReq and sets cfgDone at that same edge. Contexts resume under the new mapping in the following cycle.
- R5: The issue width of each context equals 2 times the number of pairs it owns. A context that owns no pair has width 0 and ctxRun low, which means it is suspended.
- R6: A write that holds an out-of-range code sets cfgErr, starts no flush and leaves activeMap unchanged.
- R7: A write that gives one context pairs that are not contiguous is refused in the same way as R6, for example pairs 0 and 2 owned by context 0 while context 1 owns pair 1.
- R8: Writes that arrive while flushReq is high are ignored. The mapping committed afterwards is the one that started the flush.
- R9: While no flush is pending, flushDone has no effect on activeMap, flushReq or cfgDone.
- R10: Memory port p is enabled only when lane pair p has an owner. Its portCtx field then gives the owning context. An idle port reads context 0.
- R11: Any write accepted while idle updates the status flags. A legal write clears cfgErr. A rejected write clears cfgDone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Mapping write strobe |
| cfgWrData | input | 8 | Requested mapping, 2 bits per lane pair |
| flushDone | input | 1 | Pipeline reports that the flush has finished |
| flushReq | output | 1 | Flush request; all contexts are held while high |
| cfgDone | output | 1 | The last accepted mapping has been installed |
| cfgErr | output | 1 | The last write was refused |
| activeMap | output | 8 | Mapping currently in force |
| ctxRun | output | 2 | Run enable for each context |
| ctxIssueWidth | output | 8 | Issue width for each context, 4 bits each |
| portEn | output | 4 | Memory port has an owning context |
| portCtx | output | 4 | Context served by each memory port, 1 bit each |

## Verification
Two events can land in the same cycle: a new write arriving together with flushDone, and a flushDone that completes a flush while a new write is also presented. The bench raises both inputs together in the idle state. The expected result is that the write is accepted and flushDone is ignored. It then keeps both inputs high during the flush. The expected result there is that the commit happens and the second write is dropped. A behavioural model compares every output on every cycle, so an early commit, a lost write or a committed second write shows up as a mismatch on activeMap or on flushReq.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int LANES_PER_PAIR = 2;

  typedef enum logic {ST_IDLE, ST_FLUSH} lpm_state_e;

  typedef struct packed {
    logic loadPending;
    logic commit;
    logic holdRun;
  } lpm_strobe_t;
endpackage

// File: rtl/lpm_datapath.sv
module lpm_datapath
  import lpm_pkg::*;
#(
  parameter int NUM_PAIRS = 4,
  parameter int NUM_CTX   = 2,
  localparam int FIELD_W  = $clog2(NUM_CTX + 1),
  localparam int MAP_W    = NUM_PAIRS * FIELD_W,
  localparam int IW_W     = $clog2(LANES_PER_PAIR * NUM_PAIRS + 1),
  localparam int IDX_W    = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [MAP_W-1:0]         wrData,
  input  lpm_strobe_t              strobe,
  output logic                     reqValid,
  output logic [MAP_W-1:0]         activeMap,
  output logic [NUM_CTX-1:0]       ctxRun,
  output logic [NUM_CTX*IW_W-1:0]  ctxIssueWidth,
  output logic [NUM_PAIRS-1:0]     portEn,
  output logic [NUM_PAIRS*IDX_W-1:0] portCtx
);
  logic [MAP_W-1:0] pendingMap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendingMap <= '0;
      for (int p = 0; p < NUM_PAIRS; p++)
        activeMap[p*FIELD_W +: FIELD_W] <= FIELD_W'(1);
    end else begin
      if (strobe.loadPending) pendingMap <= wrData;
      if (strobe.commit)      activeMap  <= pendingMap;
    end
  end

  // legality: every code in range, every context's pairs form one run
  always_comb begin
    logic seen, gap;
    reqValid = 1'b1;
    for (int p = 0; p < NUM_PAIRS; p++)
      if (wrData[p*FIELD_W +: FIELD_W] > FIELD_W'(NUM_CTX)) reqValid = 1'b0;
    for (int c = 0; c < NUM_CTX; c++) begin
      seen = 1'b0;
      gap  = 1'b0;
      for (int p = 0; p < NUM_PAIRS; p++) begin
        if (wrData[p*FIELD_W +: FIELD_W] == FIELD_W'(c + 1)) begin
          if (gap) reqValid = 1'b0;
          seen = 1'b1;
        end else if (seen) begin
          gap = 1'b1;
        end
      end
    end
  end

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    logic [IW_W-1:0] pairCount;
    always_comb begin
      pairCount = '0;
      for (int p = 0; p < NUM_PAIRS; p++)
        if (activeMap[p*FIELD_W +: FIELD_W] == FIELD_W'(c + 1))
          pairCount = pairCount + 1'b1;
    end
    assign ctxIssueWidth[c*IW_W +: IW_W] = pairCount * IW_W'(LANES_PER_PAIR);
    assign ctxRun[c] = (pairCount != '0) && !strobe.holdRun;
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_port
    logic [FIELD_W-1:0] owner;
    assign owner = activeMap[p*FIELD_W +: FIELD_W];
    assign portEn[p] = (owner != '0);
    assign portCtx[p*IDX_W +: IDX_W] = (owner != '0) ? IDX_W'(owner - 1'b1) : '0;
  end
endmodule

// File: rtl/lpm_control.sv
module lpm_control
  import lpm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        flushDone,
  input  logic        reqValid,
  output lpm_strobe_t strobe,
  output logic        flushReq,
  output logic        cfgDone,
  output logic        cfgErr
);
  lpm_state_e state;
  logic idleWrite;

  assign idleWrite          = (state == ST_IDLE) && wrEn;
  assign strobe.loadPending = idleWrite && reqValid;
  assign strobe.commit      = (state == ST_FLUSH) && flushDone;
  assign strobe.holdRun     = (state == ST_FLUSH);
  assign flushReq           = (state == ST_FLUSH);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cfgDone <= 1'b0;
      cfgErr  <= 1'b0;
    end else begin
      if (strobe.loadPending)  state <= ST_FLUSH;
      else if (strobe.commit)  state <= ST_IDLE;

      if (strobe.commit)       cfgDone <= 1'b1;
      else if (idleWrite)      cfgDone <= 1'b0;

      if (idleWrite)           cfgErr <= !reqValid;
    end
  end
endmodule

// File: rtl/lanepair_ctx_mapper.sv
module lanepair_ctx_mapper
  import lpm_pkg::*;
#(
  parameter int NUM_PAIRS = 4,
  parameter int NUM_CTX   = 2,
  localparam int FIELD_W  = $clog2(NUM_CTX + 1),
  localparam int MAP_W    = NUM_PAIRS * FIELD_W,
  localparam int IW_W     = $clog2(LANES_PER_PAIR * NUM_PAIRS + 1),
  localparam int IDX_W    = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cfgWrEn,
  input  logic [MAP_W-1:0]           cfgWrData,
  input  logic                       flushDone,
  output logic                       flushReq,
  output logic                       cfgDone,
  output logic                       cfgErr,
  output logic [MAP_W-1:0]           activeMap,
  output logic [NUM_CTX-1:0]         ctxRun,
  output logic [NUM_CTX*IW_W-1:0]    ctxIssueWidth,
  output logic [NUM_PAIRS-1:0]       portEn,
  output logic [NUM_PAIRS*IDX_W-1:0] portCtx
);
  lpm_strobe_t strobe;
  logic        reqValid;

  lpm_control u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(cfgWrEn), .flushDone(flushDone),
    .reqValid(reqValid), .strobe(strobe), .flushReq(flushReq),
    .cfgDone(cfgDone), .cfgErr(cfgErr)
  );

  lpm_datapath #(.NUM_PAIRS(NUM_PAIRS), .NUM_CTX(NUM_CTX)) u_dp (
    .clk(clk), .rstN(rstN), .wrData(cfgWrData), .strobe(strobe),
    .reqValid(reqValid), .activeMap(activeMap), .ctxRun(ctxRun),
    .ctxIssueWidth(ctxIssueWidth), .portEn(portEn), .portCtx(portCtx)
  );
endmodule

// File: rtl/lpm_checker.sv
module lpm_checker #(
  parameter int NUM_PAIRS = 4,
  parameter int NUM_CTX   = 2,
  localparam int FIELD_W  = $clog2(NUM_CTX + 1),
  localparam int MAP_W    = NUM_PAIRS * FIELD_W,
  localparam int IW_W     = $clog2(2 * NUM_PAIRS + 1)
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    flushDone,
  input logic                    flushReq,
  input logic                    cfgDone,
  input logic                    cfgErr,
  input logic [MAP_W-1:0]        activeMap,
  input logic [NUM_CTX-1:0]      ctxRun,
  input logic [NUM_CTX*IW_W-1:0] ctxIssueWidth
);
  int widthTotal;
  always_comb begin
    widthTotal = 0;
    for (int c = 0; c < NUM_CTX; c++)
      widthTotal += int'(ctxIssueWidth[c*IW_W +: IW_W]);
  end

  assert_hold_in_flush_R3: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |-> (ctxRun == '0));

  assert_map_frozen_R4: assert property (@(posedge clk) disable iff (!rstN)
    (flushReq && !flushDone) |=> $stable(activeMap));

  assert_done_follows_flush_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgDone) |-> ($past(flushReq) && $past(flushDone)));

  assert_width_budget_R5: assert property (@(posedge clk) disable iff (!rstN)
    widthTotal <= 2 * NUM_PAIRS);

  assert_reject_keeps_map_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgErr) |-> ($stable(activeMap) && !flushReq));

  assert_idle_map_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    !flushReq |=> $stable(activeMap));
endmodule

bind lanepair_ctx_mapper lpm_checker #(.NUM_PAIRS(NUM_PAIRS), .NUM_CTX(NUM_CTX)) u_chk (
  .clk(clk), .rstN(rstN), .flushDone(flushDone), .flushReq(flushReq),
  .cfgDone(cfgDone), .cfgErr(cfgErr), .activeMap(activeMap),
  .ctxRun(ctxRun), .ctxIssueWidth(ctxIssueWidth)
);

// File: tb/lanepair_ctx_mapper_test.sv
`timescale 1ns/1ps
module lanepair_ctx_mapper_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [7:0] cfgWrData = '0;
  logic       flushDone = 1'b0;
  logic       flushReq, cfgDone, cfgErr;
  logic [7:0] activeMap;
  logic [1:0] ctxRun;
  logic [7:0] ctxIssueWidth;
  logic [3:0] portEn;
  logic [3:0] portCtx;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 1'b0;
  bit comparing = 1'b0;

  always #4 clk = ~clk;

  lanepair_ctx_mapper uut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .flushDone(flushDone), .flushReq(flushReq), .cfgDone(cfgDone),
    .cfgErr(cfgErr), .activeMap(activeMap), .ctxRun(ctxRun),
    .ctxIssueWidth(ctxIssueWidth), .portEn(portEn), .portCtx(portCtx)
  );

  // behavioural reference
  int mMap[4];
  int mPend[4];
  bit mFlush, mDone, mErr;

  function automatic bit legalMap(logic [7:0] d);
    int first, last, cnt, v;
    for (int p = 0; p < 4; p++) if (int'(d[2*p +: 2]) > 2) return 1'b0;
    for (int c = 1; c <= 2; c++) begin
      first = -1; last = -1; cnt = 0;
      for (int p = 0; p < 4; p++) begin
        v = int'(d[2*p +: 2]);
        if (v == c) begin
          if (first < 0) first = p;
          last = p;
          cnt++;
        end
      end
      if (cnt > 0 && cnt != last - first + 1) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic int ownCount(int c);
    int n = 0;
    for (int p = 0; p < 4; p++) if (mMap[p] == c + 1) n++;
    return n;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      for (int p = 0; p < 4; p++) mMap[p] = 1;
      mFlush = 0; mDone = 0; mErr = 0;
    end else if (mFlush) begin
      if (flushDone) begin
        mMap = mPend; mFlush = 0; mDone = 1;
      end
    end else if (cfgWrEn) begin
      mDone = 0;
      if (legalMap(cfgWrData)) begin
        for (int p = 0; p < 4; p++) mPend[p] = int'(cfgWrData[2*p +: 2]);
        mFlush = 1; mErr = 0;
      end else begin
        mErr = 1;
      end
    end
  end

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compareAll();
    int em = 0;
    for (int p = 0; p < 4; p++) em |= mMap[p] << (2*p);
    check("R2", "activeMap", int'(activeMap), em);
    check("R3", "flushReq", int'(flushReq), int'(mFlush));
    check("R4", "cfgDone", int'(cfgDone), int'(mDone));
    check("R6", "cfgErr", int'(cfgErr), int'(mErr));
    for (int c = 0; c < 2; c++) begin
      check("R5", "issueWidth", int'(ctxIssueWidth[4*c +: 4]), 2 * ownCount(c));
      check("R5", "ctxRun", int'(ctxRun[c]), int'(!mFlush && ownCount(c) > 0));
    end
    for (int p = 0; p < 4; p++) begin
      check("R10", "portEn", int'(portEn[p]), int'(mMap[p] != 0));
      check("R10", "portCtx", int'(portCtx[p]), (mMap[p] != 0) ? mMap[p] - 1 : 0);
    end
  endtask

  always @(negedge clk) if (comparing) compareAll();

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) if (cycles > 50000) begin
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cycles);
    finish();
  end

  task automatic doWrite(logic [7:0] d);
    cfgWrEn = 1'b1; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic doFlush();
    flushDone = 1'b1;
    @(negedge clk);
    flushDone = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    comparing = 1'b1;
    // R1 reset state
    check("R1", "activeMap", int'(activeMap), 'h55);
    check("R1", "width ctx0", int'(ctxIssueWidth[3:0]), 8);
    check("R1", "width ctx1", int'(ctxIssueWidth[7:4]), 0);
    check("R1", "ctxRun", int'(ctxRun), 1);
    check("R1", "status", int'({flushReq, cfgDone, cfgErr}), 0);

    // R3 / R4: split into two 4-issue contexts
    doWrite(8'hA5);
    check("R3", "flushReq", int'(flushReq), 1);
    check("R3", "ctxRun held", int'(ctxRun), 0);
    check("R3", "old map kept", int'(activeMap), 'h55);
    repeat (2) @(negedge clk);
    check("R3", "still flushing", int'(flushReq), 1);
    doFlush();
    check("R4", "map committed", int'(activeMap), 'hA5);
    check("R4", "cfgDone", int'(cfgDone), 1);
    check("R4", "ctxRun resumed", int'(ctxRun), 3);
    check("R5", "split widths", int'(ctxIssueWidth), 'h44);
    check("R10", "split ports", int'({portEn, portCtx}), 'hFC);

    // R8: second write during flush dropped
    doWrite(8'hAA);
    doWrite(8'h55);
    doFlush();
    check("R8", "first write wins", int'(activeMap), 'hAA);
    check("R5", "ctx0 suspended width", int'(ctxIssueWidth[3:0]), 0);
    check("R5", "ctx0 suspended run", int'(ctxRun[0]), 0);

    // R9: stray flushDone in idle
    doFlush();
    check("R9", "map kept", int'(activeMap), 'hAA);
    check("R9", "no flush", int'(flushReq), 0);
    check("R9", "done kept", int'(cfgDone), 1);

    // R6: out-of-range code
    doWrite(8'h7D);
    check("R6", "cfgErr", int'(cfgErr), 1);
    check("R6", "no flush", int'(flushReq), 0);
    check("R6", "map kept", int'(activeMap), 'hAA);
    check("R11", "done cleared", int'(cfgDone), 0);

    // R7: non-contiguous ownership
    doWrite(8'h19);
    check("R7", "cfgErr", int'(cfgErr), 1);
    check("R7", "no flush", int'(flushReq), 0);
    check("R7", "map kept", int'(activeMap), 'hAA);

    // R11: legal write clears error; idle pairs
    doWrite(8'h04);
    check("R11", "err cleared", int'(cfgErr), 0);
    doFlush();
    check("R5", "single pair width", int'(ctxIssueWidth), 'h02);
    check("R10", "idle ports", int'(portEn), 'b0010);
    check("R10", "idle port ctx", int'(portCtx), 0);

    // coincidence: write and flushDone together, idle then flushing
    cfgWrEn = 1'b1; cfgWrData = 8'h5A; flushDone = 1'b1;
    @(negedge clk);
    check("R9", "flushDone ignored on accept", int'(activeMap), 'h04);
    check("R3", "write accepted", int'(flushReq), 1);
    cfgWrData = 8'hAA;
    @(negedge clk);
    cfgWrEn = 1'b0; flushDone = 1'b0;
    check("R8", "commit over concurrent write", int'(activeMap), 'h5A);
    check("R4", "flush ended", int'(flushReq), 0);

    // randomized traffic, reference compared every cycle
    for (int i = 0; i < 400; i++) begin
      cfgWrEn   = ($urandom_range(0, 3) == 0);
      cfgWrData = 8'($urandom);
      flushDone = ($urandom_range(0, 2) == 0);
      @(negedge clk);
    end
    cfgWrEn = 1'b0; flushDone = 1'b0;
    @(negedge clk);
    finish();
  end
endmodule